// File: doc/BRIEF.md
# Receive Lane Bit Checker

This block sits behind one receive lane and judges the quality of the recovered bit stream. One sampled bit arrives per clock. A short tap-select delay line shifts the stream by 0 to 7 bit periods, so that the checker lines up with the data it is meant to see. Each aligned bit is written into a 64-position circular capture buffer. It is also compared with the bit at the same position of a preloaded 64-bit expected pattern. Every mismatch adds one to a saturating error counter.

Configuration and readout use a slow, strobed serial register port in the core clock domain. Through this port the expected pattern is loaded, checking is switched on and off, the delay is set, and the capture buffer and error count are read back. Checking keeps running while a readout is in progress. At the end of each frame header, the value to be returned is latched, so a running count or capture is read as one consistent word. A dedicated clear input resets the error count at the start of each measurement interval. A count of zero at the end of an interval is a legal and meaningful result.

Top module: `lane_bit_checker`

## Requirements
- R1: After reset, checking is off, the delay is 0, and the expected pattern, the capture buffer and the error count all read as zero.
- R2: A serial frame consists of the bits on which ser_stb_i is high while ser_cs_i is high. It holds 8 header bits, MSB first, followed by 64 data bits, MSB first. Header bit 7 set means write; header bits 1:0 hold the register address. A write takes effect on the clock edge of the last data bit. On a read, ser_do_o shows data bit 63 after the last header bit and moves to the next bit after each data strobe. Dropping ser_cs_i abandons the frame, and a partial write has no effect.
- R3: The address map is: 0 = expected pattern (read/write), 1 = capture buffer (read only), 2 = error count (read only, zero-extended), 3 = control (read/write; bit 0 enables checking, bits 3:1 set the delay). Writes to address 1 or 2 change nothing.
- R4: In every clock cycle with checking enabled, the aligned bit is written to capture position p, which is bit p of the capture word. Then p advances by one and wraps from 63 to 0.
- R5: In every enabled cycle where the aligned bit differs from bit p of the expected pattern, the error count rises by exactly one.
- R6: The error count holds at its maximum (all ones) and does not wrap.
- R7: With cnt_clr_i high, the count is 0 after the next clock edge. The clear wins over a mismatch in the same cycle.
- R8: With delay d, the aligned bit in cycle t is the rx_bit_i value from cycle t-d.
- R9: While checking is disabled, the capture buffer, the error count and p do not change. When checking goes from disabled to enabled, p restarts at 0.
- R10: A read returns the register value latched at the clock edge of the last header bit, even if checking changes that register during the frame.
- R11: A stream that matches the pattern exactly leaves the error count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, one received bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Sampled receive bit |
| cnt_clr_i | input | 1 | Synchronous clear of the error count |
| ser_cs_i | input | 1 | Serial frame select |
| ser_stb_i | input | 1 | Serial bit strobe |
| ser_di_i | input | 1 | Serial data in |
| ser_do_o | output | 1 | Serial data out |

## Verification
The bench sweeps all eight delay settings with a pseudo-random stream. If the delay line tapped one position off, both the capture word and the count would disagree with the model. It drives an always-mismatching stream well past the maximum of a narrowed counter, where a wrapping counter would read back a small value. It asserts the clear on a mismatch cycle, where the wrong priority would leave a count of one. It re-enables checking with a matching stream, where a pointer that failed to restart would report errors. Further cases check three things: reads taken while checking runs must return the value latched at the header; abandoned write frames and writes to read-only addresses must leave registers unchanged; and strobe gaps inside a frame must not shift any bits.

// File: rtl/lane_chk_pkg.sv
package lane_chk_pkg;
  localparam int HDR_W      = 8;
  localparam int HDR_WR_BIT = 7;
  localparam int ADDR_W     = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PATTERN = 2'd0,
    REG_CAPTURE = 2'd1,
    REG_ERRCNT  = 2'd2,
    REG_CONTROL = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/lane_chk_tap_delay.sv
module lane_chk_tap_delay #(
  parameter int DLY_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic [DLY_W-1:0] sel_i,
  output logic             bit_o
);
  localparam int DEPTH = (1 << DLY_W) - 1;

  logic [DEPTH-1:0] sh_q;
  logic [DEPTH:0]   taps;

  // taps[k] is the input from k cycles ago
  assign taps  = {sh_q, bit_i};
  assign bit_o = taps[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[DEPTH-2:0], bit_i};
  end
endmodule

// File: rtl/lane_chk_sat_counter.sv
module lane_chk_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max = &cnt_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (inc_i && !at_max) cnt_q <= cnt_q + 1'b1;
  end

  assert_hold_at_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (&cnt_q)) |=> (&cnt_q));

  assert_clear_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

  assert_single_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/lane_chk_capture.sv
module lane_chk_capture #(
  parameter int PAT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [PAT_W-1:0] exp_i,
  output logic [PAT_W-1:0] cap_o,
  output logic             miss_o
);
  localparam int PTR_W = $clog2(PAT_W);

  logic [PTR_W-1:0] ptr_q;
  logic [PAT_W-1:0] mem_q;

  assign cap_o  = mem_q;
  assign miss_o = en_i && (bit_i != exp_i[ptr_q]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      mem_q <= '0;
    end else if (restart_i) begin
      ptr_q <= '0;
    end else if (en_i) begin
      mem_q[ptr_q] <= bit_i;
      ptr_q <= (ptr_q == PTR_W'(PAT_W - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assert_restart_at_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (ptr_q == '0));

  assert_frozen_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !restart_i) |=> ($stable(ptr_q) && $stable(mem_q)));

  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !restart_i && ptr_q == PTR_W'(PAT_W - 1)) |=> (ptr_q == '0));
endmodule

// File: rtl/lane_chk_serial_port.sv
module lane_chk_serial_port
  import lane_chk_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              stb_i,
  input  logic              di_i,
  output logic              do_o,
  output reg_addr_e         rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_o,
  output reg_addr_e         wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int FRAME_LEN = HDR_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [HDR_W-1:0]  hdr_now;
  logic [DATA_W-1:0] sh_q;
  logic              step;
  logic              hdr_done;
  logic              in_data;

  assign step     = cs_i && stb_i && (cnt_q != CNT_W'(FRAME_LEN));
  assign hdr_now  = {hdr_q[HDR_W-2:0], di_i};
  assign hdr_done = step && (cnt_q == CNT_W'(HDR_W - 1));
  assign in_data  = cnt_q >= CNT_W'(HDR_W);

  assign rd_addr_o = reg_addr_e'(hdr_done ? hdr_now[ADDR_W-1:0] : hdr_q[ADDR_W-1:0]);
  assign wr_addr_o = reg_addr_e'(hdr_q[ADDR_W-1:0]);
  assign wr_o      = step && hdr_q[HDR_WR_BIT] && (cnt_q == CNT_W'(FRAME_LEN - 1));
  assign wr_data_o = {sh_q[DATA_W-2:0], di_i};
  assign do_o      = sh_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hdr_q <= '0;
      sh_q  <= '0;
    end else if (!cs_i) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
      if (!in_data) hdr_q <= hdr_now;
      if (hdr_done)     sh_q <= rd_data_i;
      else if (in_data) sh_q <= {sh_q[DATA_W-2:0], di_i};
    end
  end

  assert_frame_abandon_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (cnt_q == '0));

  assert_no_write_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> !wr_o);
endmodule

// File: rtl/lane_bit_checker.sv
module lane_bit_checker
  import lane_chk_pkg::*;
#(
  parameter int PAT_W = 64,
  parameter int CNT_W = 32,
  parameter int DLY_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_bit_i,
  input  logic cnt_clr_i,
  input  logic ser_cs_i,
  input  logic ser_stb_i,
  input  logic ser_di_i,
  output logic ser_do_o
);
  localparam int REG_W = PAT_W;

  logic             en_q;
  logic [DLY_W-1:0] dly_q;
  logic [PAT_W-1:0] exp_q;
  logic [PAT_W-1:0] cap;
  logic [CNT_W-1:0] err_cnt;
  logic             aligned_bit;
  logic             miss;
  logic             restart;
  reg_addr_e        rd_addr;
  reg_addr_e        wr_addr;
  logic             wr;
  logic [REG_W-1:0] wr_data;
  logic [REG_W-1:0] rd_data;

  lane_chk_tap_delay #(.DLY_W(DLY_W)) u_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_i (rx_bit_i),
    .sel_i (dly_q),
    .bit_o (aligned_bit)
  );

  lane_chk_capture #(.PAT_W(PAT_W)) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_i    (aligned_bit),
    .en_i     (en_q),
    .restart_i(restart),
    .exp_i    (exp_q),
    .cap_o    (cap),
    .miss_o   (miss)
  );

  lane_chk_sat_counter #(.CNT_W(CNT_W)) u_errcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (miss),
    .clr_i (cnt_clr_i),
    .cnt_o (err_cnt)
  );

  lane_chk_serial_port #(.DATA_W(REG_W)) u_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (ser_cs_i),
    .stb_i    (ser_stb_i),
    .di_i     (ser_di_i),
    .do_o     (ser_do_o),
    .rd_addr_o(rd_addr),
    .rd_data_i(rd_data),
    .wr_o     (wr),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  assign restart = wr && (wr_addr == REG_CONTROL) && wr_data[0] && !en_q;

  always_comb begin
    unique case (rd_addr)
      REG_PATTERN: rd_data = exp_q;
      REG_CAPTURE: rd_data = cap;
      REG_ERRCNT:  rd_data = REG_W'(err_cnt);
      default:     rd_data = REG_W'({dly_q, en_q});
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      dly_q <= '0;
      exp_q <= '0;
    end else if (wr) begin
      if (wr_addr == REG_PATTERN) exp_q <= wr_data;
      if (wr_addr == REG_CONTROL) begin
        en_q  <= wr_data[0];
        dly_q <= wr_data[DLY_W:1];
      end
    end
  end

  assert_count_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !cnt_clr_i) |=> $stable(err_cnt));

  assert_ro_regs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && wr_addr != REG_PATTERN) |=> $stable(exp_q));
endmodule

// File: tb/lane_bit_checker_test.sv
module lane_bit_checker_test;
  localparam int CW   = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_bit_i = 1'b0, cnt_clr_i = 1'b0;
  logic ser_cs_i = 1'b0, ser_stb_i = 1'b0, ser_di_i = 1'b0;
  logic ser_do_o;

  always #10 clk = ~clk;

  lane_bit_checker #(.PAT_W(64), .CNT_W(CW), .DLY_W(3)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_bit_i(rx_bit_i), .cnt_clr_i(cnt_clr_i),
    .ser_cs_i(ser_cs_i), .ser_stb_i(ser_stb_i), .ser_di_i(ser_di_i), .ser_do_o(ser_do_o)
  );

  int total = 0, bad = 0;

  // reference state
  logic [63:0] m_exp = '0, m_cap = '0, m_snap = '0;
  int          m_err = 0, m_ptr = 0;
  logic        m_en = 1'b0;
  logic [2:0]  m_dly = '0;
  logic [7:0]  bh = '0;
  logic [15:0] lfsr = 16'hACE1;
  int          g_mode = 0;  // 0 random, 1 match, 2 mismatch
  logic        g_clr = 1'b0;
  logic [1:0]  g_addr = '0;

  function automatic logic [63:0] mval(input logic [1:0] a);
    case (a)
      2'd0: mval = m_exp;
      2'd1: mval = m_cap;
      2'd2: mval = 64'(m_err);
      default: mval = 64'({m_dly, m_en});
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic cs, input logic stb, input logic di, input bit snap,
                      output logic so);
    logic b, d;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (g_mode)
      1: b = m_exp[m_ptr];
      2: b = ~m_exp[m_ptr];
      default: b = lfsr[0];
    endcase
    rx_bit_i = b; ser_cs_i = cs; ser_stb_i = stb; ser_di_i = di; cnt_clr_i = g_clr;
    #1 so = ser_do_o;
    @(posedge clk);
    d = (m_dly == 0) ? b : bh[m_dly - 1];
    if (snap) m_snap = mval(g_addr);
    if (g_clr) m_err = 0;
    else if (m_en && d != m_exp[m_ptr] && m_err < CMAX) m_err++;
    if (m_en) begin
      m_cap[m_ptr] = d;
      m_ptr = (m_ptr + 1) % 64;
    end
    bh = {bh[6:0], b};
  endtask

  task automatic idle(input int n);
    logic so;
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 1'b0, so);
  endtask

  // full frame; abort_at < 64 drops cs after that many data bits
  task automatic xfer(input logic wr, input logic [1:0] a, input logic [63:0] data,
                      input int abort_at, output logic [63:0] rd);
    logic [7:0] h;
    logic so;
    h = {wr, 5'b0, a};
    g_addr = a;
    rd = '0;
    for (int i = 7; i >= 0; i--) tick(1'b1, 1'b1, h[i], i == 0, so);
    for (int i = 63; i >= 0; i--) begin
      if (63 - i == abort_at) break;
      if (i % 16 == 5) tick(1'b1, 1'b0, 1'b0, 1'b0, so);  // strobe gap
      tick(1'b1, 1'b1, data[i], 1'b0, so);
      rd[i] = so;
    end
    if (wr && abort_at >= 64) begin
      if (a == 2'd0) m_exp = data;
      if (a == 2'd3) begin
        if (data[0] && !m_en) m_ptr = 0;
        m_en = data[0];
        m_dly = data[3:1];
      end
    end
    tick(1'b0, 1'b0, 1'b0, 1'b0, so);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [63:0] v);
    logic [63:0] rd;
    xfer(1'b1, a, v, 64, rd);
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [63:0] v);
    xfer(1'b0, a, '0, 64, v);
  endtask

  task automatic clear_cnt();
    logic so;
    g_clr = 1'b1;
    tick(1'b0, 1'b0, 1'b0, 1'b0, so);
    g_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] v, v2;
    logic [63:0] p1, p2;
    logic so;
    p1 = 64'hA5C3_0F96_7E11_D24B;
    p2 = 64'h0123_4567_89AB_CDEF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), v);
      check("R1 reset value", v, 64'h0);
    end

    // R2/R3 pattern write and readback
    wr_reg(2'd0, p1);
    rd_reg(2'd0, v);
    check("R2 pattern readback", v, p1);
    wr_reg(2'd3, 64'h0000_0000_0000_000A);
    rd_reg(2'd3, v);
    check("R3 control readback", v, 64'hA);
    wr_reg(2'd3, 64'h0);

    // R3 read-only registers ignore writes
    wr_reg(2'd2, '1);
    rd_reg(2'd2, v);
    check("R3 count not writable", v, 64'h0);
    wr_reg(2'd1, '1);
    rd_reg(2'd1, v);
    check("R3 capture not writable", v, 64'h0);

    // R2 abandoned write
    xfer(1'b1, 2'd0, ~p1, 20, v);
    rd_reg(2'd0, v);
    check("R2 abandoned frame", v, p1);

    // R11 matching stream yields zero
    g_mode = 1;
    wr_reg(2'd3, 64'h1);
    idle(130);
    wr_reg(2'd3, 64'h0);
    rd_reg(2'd2, v);
    check("R11 zero count", v, 64'h0);
    rd_reg(2'd1, v);
    check("R4 capture equals pattern", v, p1);

    // R8/R5/R4 delay sweep
    g_mode = 0;
    for (int d = 0; d < 8; d++) begin
      clear_cnt();
      wr_reg(2'd3, 64'({3'(d), 1'b1}));
      idle(100);
      wr_reg(2'd3, 64'h0);
      rd_reg(2'd2, v);
      check("R8 R5 count vs delay", v, 64'(m_err));
      rd_reg(2'd1, v);
      check("R8 R4 capture vs delay", v, m_cap);
    end

    // R6 saturation
    clear_cnt();
    g_mode = 2;
    wr_reg(2'd3, 64'h1);
    idle(300);
    wr_reg(2'd3, 64'h0);
    rd_reg(2'd2, v);
    check("R6 saturated", v, 64'(CMAX));

    // R7 clear wins over a mismatch
    wr_reg(2'd3, 64'h1);
    idle(5);
    clear_cnt();
    g_mode = 1;
    idle(3);
    rd_reg(2'd2, v);
    check("R7 clear priority", v, 64'h0);
    g_mode = 2;
    idle(4);
    wr_reg(2'd3, 64'h0);
    rd_reg(2'd2, v);
    check("R7 count after clear", v, 64'(m_err));

    // R10 snapshot while running
    clear_cnt();
    g_mode = 0;
    wr_reg(2'd3, 64'h5);
    idle(20);
    rd_reg(2'd2, v);
    check("R10 count snapshot", v, m_snap);
    rd_reg(2'd1, v);
    check("R10 capture snapshot", v, m_snap);

    // R9 frozen while disabled
    wr_reg(2'd3, 64'h0);
    rd_reg(2'd1, v);
    rd_reg(2'd2, v2);
    idle(50);
    clear_cnt();
    check("R9 capture frozen", mval(2'd1), v);
    rd_reg(2'd1, v);
    check("R9 capture held", v, m_cap);
    rd_reg(2'd2, v);
    check("R9 count after clear", v, 64'h0);

    // R9 pointer restart on enable
    wr_reg(2'd0, p2);
    g_mode = 1;
    wr_reg(2'd3, 64'h1);
    idle(37);
    wr_reg(2'd3, 64'h0);
    rd_reg(2'd2, v);
    check("R9 restart aligned", v, 64'h0);
    rd_reg(2'd1, v);
    check("R9 R4 capture after restart", v, p2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule